// File: doc/BRIEF.md
# Current-Reset Boost PWM Generator

This block drives the power switch of a boost converter that runs in current-reset mode. Every switching cycle starts with the switch on for a fixed, programmed number of clocks. The switch then turns off, and the block waits for a comparator to signal that the inductor current has fallen below its threshold. When that signal arrives during the off-time, the period counter is cleared and a new cycle begins at once. The cycle is therefore shorter than the programmed period, which acts only as an upper bound when no comparator signal arrives.

The comparator level comes from an analog domain, so it is synchronized before use. Each assertion of the level can start at most one new cycle. An optional current-limit mode lets the same comparator level end the on-pulse early without starting a new cycle. The on-time and period inputs are captured only at the start of each cycle, so software can change them at any moment without producing a malformed pulse. While the block is disabled, the drive output is low and the counter is held at zero.

Top module: `crst_pwm`

## Requirements
- R1: While `en_i` is low, `drv_o` and `start_o` are low from the first rising edge that samples `en_i` low.
- R2: The first rising edge that samples `en_i` high after a disabled period starts a cycle: `start_o` is high for exactly that one clock, and `drv_o` is high if the captured on-time is nonzero.
- R3: Counting the start clock as clock 0, `drv_o` is high on clocks 0 to T-1 of a cycle and low afterwards, where T is the captured on-time. T = 0 gives no high clock at all.
- R4: With no comparator restart, the next `start_o` comes exactly max(P,1) clocks after the previous one, where P is the captured period. If T >= P, `drv_o` stays high for the whole cycle.
- R5: A rising `cmp_i` level during the off-time (`drv_o` low, block enabled) starts a new cycle on the third rising edge after the change. The period counter restarts from that point, so the next expiry comes P clocks later.
- R6: One assertion of `cmp_i` starts at most one cycle. While the level stays high, no further early restart occurs, and the cycle then ends only at period expiry. A new restart needs the synchronized level to go low first.
- R7: With `clip_en_i` low, a `cmp_i` level that the synchronizer sees during the on-time has no effect on `drv_o` or on the cycle length. If that level is still high when the off-time begins, it does not restart the cycle.
- R8: With `clip_en_i` high, a rising `cmp_i` level during the on-time drives `drv_o` low on the third rising edge after the change. `start_o` stays low and the cycle runs on to its period expiry.
- R9: Changes to `ton_i` and `per_i` during a cycle take effect only at the next cycle start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Run enable; low holds the drive off and the counter at zero |
| clip_en_i | input | 1 | When high, a comparator level during the on-time ends the pulse early |
| ton_i | input | 16 | On-time in clocks, captured at each cycle start |
| per_i | input | 16 | Maximum period in clocks, captured at each cycle start |
| cmp_i | input | 1 | Asynchronous comparator level; high means current below threshold |
| drv_o | output | 1 | Switch drive |
| start_o | output | 1 | One-clock strobe on the first clock of every cycle |

## Verification
An enable change shows on the outputs after one rising edge. A comparator change needs three rising edges: two synchronizer flops and the state register. A period expiry produces the strobe exactly P edges after the previous strobe. The bench changes inputs 2 ns after a rising edge and samples the outputs at the same offset after each later edge. It counts edges from the cycle start, so every expected value is tied to a known edge count, including the exact edge on which a restart or a clipped pulse must appear and the edges just before it, where it must not.

// File: rtl/crst_pkg.sv
package crst_pkg;
  parameter int PWM_W = 16;

  typedef struct packed {
    logic [PWM_W-1:0] ton;
    logic [PWM_W-1:0] per;
  } cfg_t;
endpackage

// File: rtl/crst_sync.sv
module crst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb chain_d[i] = d_i;
      end else begin : g_rest
        always_comb chain_d[i] = chain_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_d[i];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/crst_evt.sv
module crst_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_s_i,
  input  logic run_i,
  input  logic drv_i,
  input  logic clip_en_i,
  output logic restart_o,
  output logic clip_o
);
  logic armed_q;
  logic armed_d;
  logic fire;

  // A level may act once; it re-arms only after it has been seen low.
  always_comb begin
    fire      = cmp_s_i && armed_q;
    restart_o = fire && run_i && !drv_i;
    clip_o    = fire && run_i && drv_i && clip_en_i;
    armed_d   = !cmp_s_i || (armed_q && !run_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  AST_ONE_RESTART_PER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o); // R6

  AST_NO_CLIP_AFTER_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
    clip_o |=> !clip_o); // R8
endmodule

// File: rtl/crst_cfg.sv
module crst_cfg
  import crst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [PWM_W-1:0] ton_i,
  input  logic [PWM_W-1:0] per_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (ld_i) begin
      cfg_d.ton = ton_i;
      cfg_d.per = per_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/crst_core.sv
module crst_core
  import crst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  cfg_t cfg_i,
  input  logic restart_req_i,
  input  logic clip_req_i,
  output logic ld_o,
  output logic run_o,
  output logic drv_o,
  output logic start_o
);
  localparam int CW = PWM_W + 1;

  logic             run_q, run_d;
  logic [PWM_W-1:0] cnt_q, cnt_d;
  logic             clip_q, clip_d;
  logic             start_q, start_d;
  logic             on_win;
  logic             expire;
  logic             begin_cyc;
  logic             new_cyc;
  logic [CW-1:0]    cnt_inc;

  always_comb begin
    cnt_inc   = {1'b0, cnt_q} + CW'(1);
    on_win    = cnt_q < cfg_i.ton;
    expire    = cnt_inc >= {1'b0, cfg_i.per};
    begin_cyc = en_i && !run_q;
    new_cyc   = begin_cyc || (run_q && (expire || restart_req_i));
  end

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    clip_d  = clip_q;
    start_d = 1'b0;
    ld_o    = 1'b0;
    if (!en_i) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      clip_d = 1'b0;
    end else if (new_cyc) begin
      run_d   = 1'b1;
      cnt_d   = '0;
      clip_d  = 1'b0;
      start_d = 1'b1;
      ld_o    = 1'b1;
    end else begin
      cnt_d  = cnt_inc[PWM_W-1:0];
      clip_d = clip_q || clip_req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      clip_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      clip_q  <= clip_d;
      start_q <= start_d;
    end
  end

  assign run_o   = run_q;
  assign drv_o   = run_q && on_win && !clip_q;
  assign start_o = start_q;

  AST_DISABLE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!drv_o && !start_o && cnt_q == '0)); // R1

  AST_ENABLE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (start_q && cnt_q == '0)); // R2

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q == '0 || cnt_inc <= {1'b0, cfg_i.per})); // R4

  AST_CFG_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i != $past(cfg_i)) |-> start_q); // R9

  AST_CLIP_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clip_q) |-> (run_q && !start_q)); // R8
endmodule

// File: rtl/crst_pwm.sv
module crst_pwm
  import crst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clip_en_i,
  input  logic [PWM_W-1:0] ton_i,
  input  logic [PWM_W-1:0] per_i,
  input  logic             cmp_i,
  output logic             drv_o,
  output logic             start_o
);
  logic cmp_s;
  logic restart_req;
  logic clip_req;
  logic ld;
  logic run;
  cfg_t cfg;

  crst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  crst_evt u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_s_i   (cmp_s),
    .run_i     (run),
    .drv_i     (drv_o),
    .clip_en_i (clip_en_i),
    .restart_o (restart_req),
    .clip_o    (clip_req)
  );

  crst_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (ld),
    .ton_i (ton_i),
    .per_i (per_i),
    .cfg_o (cfg)
  );

  crst_core u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .cfg_i         (cfg),
    .restart_req_i (restart_req),
    .clip_req_i    (clip_req),
    .ld_o          (ld),
    .run_o         (run),
    .drv_o         (drv_o),
    .start_o       (start_o)
  );
endmodule

// File: tb/crst_pwm_test.sv
`timescale 1ns/1ps
module crst_pwm_test;
  logic        clk;
  logic        rst_n;
  logic        en_i;
  logic        clip_en_i;
  logic [15:0] ton_i;
  logic [15:0] per_i;
  logic        cmp_i;
  logic        drv_o;
  logic        start_o;

  int n_chk;
  int n_fail;

  crst_pwm uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .clip_en_i (clip_en_i),
    .ton_i     (ton_i),
    .per_i     (per_i),
    .cmp_i     (cmp_i),
    .drv_o     (drv_o),
    .start_o   (start_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Leaves the bench 2 ns after the start edge (clock 0 of a cycle).
  task automatic begin_cycle(input int ton, input int per, input bit clip);
    en_i = 1'b0;
    cmp_i = 1'b0;
    repeat (4) tick();
    ton_i = 16'(ton);
    per_i = 16'(per);
    clip_en_i = clip;
    en_i = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    check("R1 reset drv", int'(drv_o), 0);
    check("R1 reset start", int'(start_o), 0);
  endtask

  task automatic t_basic();
    begin_cycle(3, 8, 1'b0);
    check("R2 start strobe", int'(start_o), 1);
    check("R2 drv at start", int'(drv_o), 1);
    for (int k = 1; k < 8; k++) begin
      tick();
      check("R3 on-time drv", int'(drv_o), (k < 3) ? 1 : 0);
      check("R4 no early start", int'(start_o), 0);
    end
    tick();
    check("R4 start at period", int'(start_o), 1);
    check("R3 drv at new cycle", int'(drv_o), 1);
    tick();
    check("R2 strobe one clock", int'(start_o), 0);
  endtask

  task automatic t_disable();
    begin_cycle(5, 10, 1'b0);
    tick();
    en_i = 1'b0;
    tick();
    check("R1 drv low after disable", int'(drv_o), 0);
    check("R1 start low after disable", int'(start_o), 0);
    for (int k = 0; k < 12; k++) begin
      tick();
      check("R1 stays off", int'(drv_o) + int'(start_o), 0);
    end
  endtask

  task automatic t_bounds();
    begin_cycle(0, 4, 1'b0);
    check("R3 ton zero start", int'(start_o), 1);
    for (int k = 1; k <= 4; k++) begin
      tick();
      check("R3 ton zero drv", int'(drv_o), 0);
      check("R4 ton zero period", int'(start_o), (k == 4) ? 1 : 0);
    end
    begin_cycle(5, 3, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      tick();
      check("R4 ton over period drv", int'(drv_o), 1);
      check("R4 ton over period start", int'(start_o), (k % 3 == 0) ? 1 : 0);
    end
    begin_cycle(0, 0, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      tick();
      check("R4 zero period start each clock", int'(start_o), 1);
    end
  endtask

  task automatic t_restart();
    begin_cycle(3, 20, 1'b0);
    repeat (5) tick();
    cmp_i = 1'b1;
    tick();
    check("R5 no restart edge 1", int'(start_o), 0);
    tick();
    check("R5 no restart edge 2", int'(start_o), 0);
    tick();
    check("R5 restart on edge 3", int'(start_o), 1);
    check("R5 drv on at restart", int'(drv_o), 1);
    for (int k = 1; k < 20; k++) begin
      tick();
      check("R6 held level no second restart", int'(start_o), 0);
      check("R5 on-time after restart", int'(drv_o), (k < 3) ? 1 : 0);
    end
    tick();
    check("R5 expiry counted from restart", int'(start_o), 1);
    cmp_i = 1'b0;
  endtask

  task automatic t_ignore();
    begin_cycle(6, 30, 1'b0);
    tick();
    cmp_i = 1'b1;
    tick();
    tick();
    cmp_i = 1'b0;
    for (int k = 3; k < 30; k++) begin
      check("R7 on-time unaffected", int'(drv_o), (k < 6) ? 1 : 0);
      check("R7 no start from on-time level", int'(start_o), 0);
      tick();
    end
    check("R7 full period kept", int'(start_o), 1);

    begin_cycle(4, 30, 1'b0);
    tick();
    cmp_i = 1'b1;
    for (int k = 2; k <= 10; k++) begin
      tick();
      check("R7 level spanning on-time ignored", int'(start_o), 0);
    end
    cmp_i = 1'b0;
    for (int k = 11; k <= 14; k++) begin
      tick();
      check("R7 no start while low", int'(start_o), 0);
    end
    cmp_i = 1'b1;
    tick();
    tick();
    check("R6 re-armed not yet", int'(start_o), 0);
    tick();
    check("R6 re-armed restart", int'(start_o), 1);
    cmp_i = 1'b0;
  endtask

  task automatic t_clip();
    begin_cycle(10, 25, 1'b1);
    tick();
    tick();
    cmp_i = 1'b1;
    tick();
    check("R8 drv before clip", int'(drv_o), 1);
    tick();
    check("R8 drv before clip edge 2", int'(drv_o), 1);
    tick();
    check("R8 drv clipped on edge 3", int'(drv_o), 0);
    check("R8 no start on clip", int'(start_o), 0);
    cmp_i = 1'b0;
    for (int k = 6; k < 25; k++) begin
      tick();
      check("R8 stays off no start", int'(drv_o) + int'(start_o), 0);
    end
    tick();
    check("R8 period expiry after clip", int'(start_o), 1);
    check("R8 new cycle drives again", int'(drv_o), 1);
  endtask

  task automatic t_reload();
    begin_cycle(2, 6, 1'b0);
    tick();
    ton_i = 16'd5;
    per_i = 16'd9;
    tick();
    check("R9 old on-time kept", int'(drv_o), 0);
    for (int k = 3; k < 6; k++) begin
      tick();
      check("R9 old period kept", int'(start_o), 0);
    end
    tick();
    check("R9 start at old period", int'(start_o), 1);
    for (int k = 1; k <= 9; k++) begin
      tick();
      if (k < 9) check("R9 new on-time", int'(drv_o), (k < 5) ? 1 : 0);
      check("R9 new period", int'(start_o), (k == 9) ? 1 : 0);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    en_i = 1'b0;
    clip_en_i = 1'b0;
    ton_i = '0;
    per_i = '0;
    cmp_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_disable();
    t_bounds();
    t_restart();
    t_ignore();
    t_clip();
    t_reload();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule